// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz tick enable into periodic event strobes at a programmable rate. A 4-bit rate code picks the period: the period in ticks is a power of two taken from an effective code, where codes 1 and 2 map up to 8 and 9 and codes 3 to 15 are used as given. Events are phase-aligned to a free-running tick counter, so every event lands on a whole multiple of the current period. A new rate code therefore takes effect at the next boundary of the new period, not at a fixed delay from the moment it was written.

Each event gives a one-cycle strobe that a flag register elsewhere uses to set its periodic flag. The same event also gives an interrupt-request strobe when periodic interrupts are enabled, and a single-cycle pulse on a separate output when square-wave output is enabled. If the rate code is zero, or both enables are clear, no events occur at all. The tick counter keeps running in these cases, so alignment is kept. There is no streaming data path, so every pin is a plain level or strobe.

Top module: `prg_rate_gen`

## Requirements
- R1: While the synchronous reset `rst_i` is high at a rising edge, all three outputs are 0 in the following cycle and the tick counter returns to zero. The first tick after reset brings the count to 1.
- R2: A rate code of 0 produces no event, interrupt or pulse, whatever the enables are.
- R3: With both `pie_i` and `sqe_i` low, no events are produced. Enabling part-way through a period yields the next aligned event with no extra one.
- R4: For rate codes 3 to 15, an event occurs on exactly those ticks that bring the tick count (ticks since reset, modulo 65536) to a multiple of 2^(code-1).
- R5: Rate code 1 behaves like code 8 (period 128 ticks), and rate code 2 behaves like code 9 (period 256 ticks).
- R6: `irq_o` pulses with an event only when `pie_i` is high, and never without an event.
- R7: `sqw_o` pulses with an event only when `sqe_i` is high, and never without an event. Each pulse lasts one clock cycle rather than forming a 50% duty wave.
- R8: `evt_o` is high for a single clock cycle per event.
- R9: After the rate code changes, the next event falls on the next multiple of the new period, with no spurious event at the switch.
- R10: No output rises in a cycle that does not follow a tick. All outputs appear exactly one clock after the rising edge that samples `tick_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable at 32.768 kHz rate |
| rate_i | input | 4 | Rate code (0 = off, 1/2 remapped to 8/9) |
| pie_i | input | 1 | Periodic interrupt enable |
| sqe_i | input | 1 | Square-wave pulse enable |
| evt_o | output | 1 | Periodic event strobe (sets periodic flag) |
| irq_o | output | 1 | Interrupt request strobe |
| sqw_o | output | 1 | Square-wave pulse |

## Verification
All three outputs are due one clock after the rising edge that samples a tick. A disabled or gapped tick must give zeros in that same slot. The driver applies inputs at the falling edge and pushes the expected output triple for the next cycle. The monitor pops one entry 2 ns after each rising edge, so every cycle is compared at the exact slot its result is due. Event totals per phase are also checked against counts worked out by hand from the period and tick count.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int unsigned CODE_W_P  = 4;
  localparam int unsigned REMAP_OFS = 7;   // codes 1/2 lifted by this amount
  localparam int unsigned REMAP_MAX = 2;

  // effective exponent of the period (period = 2**exp)
  function automatic logic [CODE_W_P-1:0] period_exp(input logic [CODE_W_P-1:0] code);
    logic [CODE_W_P-1:0] eff;
    if (code <= CODE_W_P'(REMAP_MAX)) eff = code + CODE_W_P'(REMAP_OFS);
    else                              eff = code;
    return eff - CODE_W_P'(1);
  endfunction

  typedef struct packed {
    logic evt;
    logic irq;
    logic sqw;
  } prg_strobe_t;
endpackage

// File: rtl/prg_prescaler.sv
module prg_prescaler #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R10
  count_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/prg_rate_map.sv
module prg_rate_map
  import prg_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = CODE_W_P
) (
  input  logic [CODE_W-1:0] rate_i,
  output logic              code_on_o,
  output logic [CNT_W-1:0]  mask_o
);
  logic [CODE_W_P-1:0] expo;

  assign expo      = period_exp(CODE_W_P'(rate_i));
  assign code_on_o = (rate_i != '0);

  // thermometer mask of the low (period-1) bits
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (i < int'(expo));
  end

  // R5
  always_comb begin
    if (rate_i == CODE_W'(1)) remap_one_chk: assert (expo == CODE_W_P'(7));
  end
endmodule

// File: rtl/prg_strobe_gen.sv
module prg_strobe_gen
  import prg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             code_on_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             pie_i,
  input  logic             sqe_i,
  output prg_strobe_t      strb_o
);
  logic        aligned;
  logic        fire;
  prg_strobe_t strb_q;

  assign aligned = ((cnt_nxt_i & mask_i) == '0);
  assign fire    = tick_i && code_on_i && (pie_i || sqe_i) && aligned;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      strb_q <= '0;
    end else begin
      strb_q.evt <= fire;
      strb_q.irq <= fire && pie_i;
      strb_q.sqw <= fire && sqe_i;
    end
  end

  assign strb_o = strb_q;

  // R2
  off_code_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !code_on_i |=> !strb_q.evt);
endmodule

// File: rtl/prg_rate_gen.sv
module prg_rate_gen
  import prg_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = CODE_W_P
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] rate_i,
  input  logic              pie_i,
  input  logic              sqe_i,
  output logic              evt_o,
  output logic              irq_o,
  output logic              sqw_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] mask;
  logic             code_on;
  prg_strobe_t      strb;

  prg_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt)
  );

  prg_rate_map #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_map (
    .rate_i(rate_i), .code_on_o(code_on), .mask_o(mask)
  );

  prg_strobe_gen #(.CNT_W(CNT_W)) u_gen (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i),
    .code_on_i(code_on), .mask_i(mask), .cnt_nxt_i(cnt_nxt),
    .pie_i(pie_i), .sqe_i(sqe_i), .strb_o(strb)
  );

  assign evt_o = strb.evt;
  assign irq_o = strb.irq;
  assign sqw_o = strb.sqw;

  // R6
  irq_needs_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (evt_o && $past(pie_i)));

  // R7
  sqw_needs_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sqw_o |-> (evt_o && $past(sqe_i)));

  // R8
  evt_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_o |=> !evt_o);

  // R10
  evt_after_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_o |-> $past(tick_i));

  // R3
  evt_needs_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_o |-> ($past(pie_i) || $past(sqe_i)));

  // R4
  evt_aligned_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_o |-> ((cnt & $past(mask)) == '0));
endmodule

// File: tb/tb_prg_rate_gen.sv
module tb_prg_rate_gen;
  typedef struct {
    logic [2:0] exp_v;   // {evt, irq, sqw}
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] rate = 4'd0;
  logic       pie = 1'b0;
  logic       sqe = 1'b0;
  logic       evt, irq, sqw;

  item_t      q[$];
  int         n_run = 0, n_fail = 0;
  int         n_evt = 0, n_irq = 0, n_sqw = 0;
  logic [15:0] cnt_m = '0;
  string      cur_tag = "R1";
  bit         done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  prg_rate_gen dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .rate_i(rate),
    .pie_i(pie), .sqe_i(sqe), .evt_o(evt), .irq_o(irq), .sqw_o(sqw)
  );

  function automatic int exp_of(input logic [3:0] c);
    int e;
    e = (c <= 4'd2) ? int'(c) + 7 : int'(c);
    return e - 1;
  endfunction

  // driver: one cycle of stimulus plus its expected result
  task automatic cycle(input logic r, input logic t);
    item_t it;
    logic [15:0] nxt, msk;
    logic ev;
    @(negedge clk);
    rst = r; tick = t;
    ev = 1'b0;
    if (r) cnt_m = '0;
    else if (t) begin
      nxt = cnt_m + 16'd1;
      msk = 16'((32'd1 << exp_of(rate)) - 1);
      ev  = (rate != 4'd0) && (pie || sqe) && ((nxt & msk) == 16'd0);
      cnt_m = nxt;
    end
    it.exp_v = {ev, ev & pie, ev & sqe};
    it.tag   = cur_tag;
    q.push_back(it);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cycle(1'b0, 1'b1);
      cycle(1'b0, 1'b0);
    end
  endtask

  task automatic do_reset();
    cur_tag = "R1";
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
  endtask

  task automatic clr();
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
    n_evt = 0; n_irq = 0; n_sqw = 0;
  endtask

  task automatic chk(input string tag, input int got, input int expv);
    n_run++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s count: actual %0d expected %0d", tag, got, expv);
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if ({evt, irq, sqw} !== it.exp_v) begin
        n_fail++;
        $display("FAIL %s cycle: actual %b expected %b", it.tag, {evt, irq, sqw}, it.exp_v);
      end
      if (evt) n_evt++;
      if (irq) n_irq++;
      if (sqw) n_sqw++;
    end
  end

  initial begin
    do_reset();
    // R1: outputs low right after reset
    @(negedge clk);
    chk("R1", int'({evt, irq, sqw}), 0);

    // R4 / R6: code 3, period 4, interrupts on
    rate = 4'd3; pie = 1'b1; sqe = 1'b0; cur_tag = "R4"; clr();
    ticks(64);
    clr_wait();
    chk("R4", n_evt, 16); chk("R6", n_irq, 16); chk("R7", n_sqw, 0);

    // R2: code 0 silent
    do_reset(); rate = 4'd0; pie = 1'b1; sqe = 1'b1; cur_tag = "R2"; clr();
    ticks(64); clr_wait();
    chk("R2", n_evt + n_irq + n_sqw, 0);

    // R3: no enables, silent
    do_reset(); rate = 4'd5; pie = 1'b0; sqe = 1'b0; cur_tag = "R3"; clr();
    ticks(64); clr_wait();
    chk("R3", n_evt, 0);

    // R7: square-wave pulses only
    do_reset(); rate = 4'd5; pie = 1'b0; sqe = 1'b1; cur_tag = "R7"; clr();
    ticks(64); clr_wait();
    chk("R7", n_sqw, 4); chk("R6", n_irq, 0); chk("R8", n_evt, 4);

    // R5: remapped low codes
    do_reset(); rate = 4'd1; pie = 1'b1; sqe = 1'b0; cur_tag = "R5"; clr();
    ticks(512); clr_wait();
    chk("R5", n_evt, 4);
    do_reset(); rate = 4'd2; cur_tag = "R5"; clr();
    ticks(512); clr_wait();
    chk("R5", n_evt, 2);

    // R9: rate change mid-period
    do_reset(); rate = 4'd6; pie = 1'b1; cur_tag = "R9"; clr();
    ticks(40);
    rate = 4'd4;
    ticks(8); clr_wait();
    chk("R9", n_evt, 2);

    // R10: no ticks, no events
    do_reset(); rate = 4'd3; pie = 1'b1; sqe = 1'b1; cur_tag = "R10"; clr();
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0);
    clr_wait();
    chk("R10", n_evt, 0);

    // R3: enable part-way through a period
    do_reset(); rate = 4'd4; pie = 1'b0; sqe = 1'b0; cur_tag = "R3"; clr();
    ticks(6);
    pie = 1'b1;
    ticks(2); clr_wait();
    chk("R3", n_evt, 1);

    // R4: longest period, code 15
    do_reset(); rate = 4'd15; pie = 1'b1; sqe = 1'b1; cur_tag = "R4"; clr();
    ticks(16384); clr_wait();
    chk("R4", n_evt, 1); chk("R7", n_sqw, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic clr_wait();
    cycle(1'b0, 1'b0);
    @(posedge clk); #3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule